// File: doc/BRIEF.md
# Packet-Committing FIFO Write Controller

This block drives the write side of a synchronous slave FIFO from the host side. It takes a stream of beats (bytes or words, set by a parameter), each with a valid flag and an end-of-packet marker. It presents them to the device as registered data with a write strobe. The device commits a packet by itself once the number of beats written equals a programmed auto-commit length. Any packet that ends before that length must be closed with a packet-end strobe.

The controller counts the beats of the packet in progress so that it knows where the device will commit by itself. It raises packet-end only for packets that end short, and always in the same cycle as their final write. One case needs care: a one-beat short packet that directly follows an auto-committed packet. If packet-end comes too soon after the write that completed the auto commit, the device drops the one-beat packet. The controller therefore inserts one idle cycle in that case only. While the device reports full, the upstream stream is stalled and nothing is written.

Top module: `pkt_wr_ctrl`

## Requirements
- R1: A synchronous active-high reset forces `fifo_wr` and `fifo_pktend` low in the cycle after it and clears the beat count, so the next packet counts from its first beat.
- R2: A beat accepted at a clock edge (`in_valid` and `in_ready` both high) appears on `fifo_data` with `fifo_wr` high during the following cycle. Beats are written in the order accepted, one per cycle when no stall applies.
- R3: When a write brings the beat count to `auto_len`, no packet-end is raised with it, and the count restarts at zero for the next beat.
- R4: The final beat of a packet shorter than `auto_len` is written with `fifo_pktend` high in the same cycle as its `fifo_wr`. `fifo_pktend` lasts one cycle and is never high without `fifo_wr`.
- R5: While `dev_full` is high, `in_ready` is low and no write is issued in the following cycle. The held beat is written once `dev_full` falls, with no loss or duplication.
- R6: A one-beat short packet that directly follows the write completing an auto commit is written with at least one idle cycle between that write and its own write plus packet-end.
- R7: A short packet of two or more beats following an auto commit is written without any inserted idle cycle.
- R8: A packet whose end marker lands exactly on the `auto_len`-th beat is written with no packet-end strobe.
- R9: With `auto_len` equal to 1, every beat commits by itself: no packet-end is ever raised and no idle cycle is inserted, even when every beat carries the end marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | DATA_W | Beat data from upstream |
| in_valid | input | 1 | Upstream beat is present |
| in_last | input | 1 | Beat ends its packet |
| in_ready | output | 1 | Controller accepts the beat this cycle |
| auto_len | input | LEN_W | Beats per automatically committed packet (at least 1) |
| dev_full | input | 1 | Device FIFO full flag, active high |
| fifo_data | output | DATA_W | Registered data to the device |
| fifo_wr | output | 1 | Registered write strobe, active high |
| fifo_pktend | output | 1 | Registered packet-end strobe, active high |

## Verification
The bench sends a full packet followed at once by a one-beat packet. It measures the gap between the two writes: a design without the guard writes them in adjacent cycles, and the device would lose the short packet. It also sends a multi-beat short packet after an auto commit and checks that no gap appears, which catches a guard that stalls too broadly. A packet whose end marker lands exactly on the length must get no strobe, because a design that strobes it would send an extra zero-length packet. The bench also checks that a held beat is written exactly once after `dev_full` clears, that a mid-packet reset restarts counting, and that `auto_len` of 1 never produces a strobe or a stall.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  localparam int DEF_DATA_W = 16;
  localparam int DEF_LEN_W  = 10;

  typedef enum logic [1:0] {
    CMT_NONE  = 2'd0,
    CMT_AUTO  = 2'd1,
    CMT_SHORT = 2'd2
  } commit_e;
endpackage

// File: rtl/pkt_beat_ctr.sv
module pkt_beat_ctr #(
  parameter int LEN_W = pkt_pkg::DEF_LEN_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step,
  input  logic                last,
  input  logic [LEN_W-1:0]    auto_len,
  output pkt_pkg::commit_e    kind,
  output logic                would_hit,
  output logic [LEN_W-1:0]    cnt
);
  localparam logic [LEN_W-1:0] ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  logic [LEN_W-1:0] cnt_nxt;
  assign cnt_nxt   = cnt + ONE;
  assign would_hit = (cnt_nxt == auto_len);

  always_comb begin
    kind = pkt_pkg::CMT_NONE;
    if (step) begin
      if (would_hit)  kind = pkt_pkg::CMT_AUTO;
      else if (last)  kind = pkt_pkg::CMT_SHORT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                              cnt <= '0;
    else if (kind != pkt_pkg::CMT_NONE)   cnt <= '0;
    else if (step)                        cnt <= cnt_nxt;
  end

  p_cnt_clear_r1: assert property (@(posedge clk) rst |=> (cnt == '0));
  p_restart_r3: assert property (@(posedge clk) disable iff (rst)
    (kind != pkt_pkg::CMT_NONE) |=> (cnt == '0));
endmodule

// File: rtl/pkt_gap_guard.sv
module pkt_gap_guard (
  input  logic clk,
  input  logic rst,
  input  logic accept_auto,
  input  logic in_valid,
  input  logic in_last,
  input  logic would_hit,
  output logic ac_out,
  output logic hold
);
  always_ff @(posedge clk) begin
    if (rst) ac_out <= 1'b0;
    else     ac_out <= accept_auto;
  end

  assign hold = ac_out && in_valid && in_last && !would_hit;

  p_hold_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    hold |=> !ac_out);
endmodule

// File: rtl/pkt_out_reg.sv
module pkt_out_reg #(
  parameter int DATA_W = pkt_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [DATA_W-1:0] in_data,
  input  pkt_pkg::commit_e  kind,
  output logic [DATA_W-1:0] fifo_data,
  output logic              fifo_wr,
  output logic              fifo_pktend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_wr     <= 1'b0;
      fifo_pktend <= 1'b0;
    end else begin
      fifo_wr     <= accept;
      fifo_pktend <= (kind == pkt_pkg::CMT_SHORT);
    end
  end

  always_ff @(posedge clk) begin
    if (accept) fifo_data <= in_data;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!fifo_wr && !fifo_pktend));
  p_write_follows_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> fifo_wr);
endmodule

// File: rtl/pkt_wr_ctrl.sv
module pkt_wr_ctrl #(
  parameter int DATA_W = pkt_pkg::DEF_DATA_W,
  parameter int LEN_W  = pkt_pkg::DEF_LEN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  input  logic [LEN_W-1:0]  auto_len,
  input  logic              dev_full,
  output logic [DATA_W-1:0] fifo_data,
  output logic              fifo_wr,
  output logic              fifo_pktend
);
  pkt_pkg::commit_e kind;
  logic             would_hit;
  logic [LEN_W-1:0] cnt;
  logic             ac_out;
  logic             hold;
  logic             accept;

  assign in_ready = !rst && !dev_full && !hold;
  assign accept   = in_valid && in_ready;

  pkt_beat_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk(clk), .rst(rst), .step(accept), .last(in_last),
    .auto_len(auto_len), .kind(kind), .would_hit(would_hit), .cnt(cnt)
  );

  pkt_gap_guard u_guard (
    .clk(clk), .rst(rst), .accept_auto(kind == pkt_pkg::CMT_AUTO),
    .in_valid(in_valid), .in_last(in_last), .would_hit(would_hit),
    .ac_out(ac_out), .hold(hold)
  );

  pkt_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .accept(accept), .in_data(in_data), .kind(kind),
    .fifo_data(fifo_data), .fifo_wr(fifo_wr), .fifo_pktend(fifo_pktend)
  );

  p_pktend_has_wr_r4: assert property (@(posedge clk) disable iff (rst)
    fifo_pktend |-> fifo_wr);
  p_pktend_single_r4: assert property (@(posedge clk) disable iff (rst)
    fifo_pktend |=> !fifo_pktend || $past(accept));
  p_full_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    dev_full |=> !fifo_wr);
  p_gap_after_auto_r6: assert property (@(posedge clk) disable iff (rst)
    ac_out |=> !(fifo_wr && fifo_pktend && (cnt == '0) && $past(ac_out)
                 && $past(in_last) && !$past(would_hit)));
  p_auto_no_pktend_r3: assert property (@(posedge clk) disable iff (rst)
    ac_out |-> !fifo_pktend);
endmodule

// File: tb/pkt_wr_ctrl_test.sv
module pkt_wr_ctrl_test;
  localparam int CLK = 10;
  localparam int DW  = 16;
  localparam int LW  = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] in_data = '0;
  logic          in_valid = 1'b0;
  logic          in_last = 1'b0;
  logic          in_ready;
  logic [LW-1:0] auto_len = LW'(4);
  logic          dev_full = 1'b0;
  logic [DW-1:0] fifo_data;
  logic          fifo_wr;
  logic          fifo_pktend;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int cyc = 0;
  int lg = 0;
  logic [DW-1:0] log_d [64];
  bit            log_pe [64];
  int            log_c [64];

  always #(CLK/2) clk = ~clk;

  pkt_wr_ctrl #(.DATA_W(DW), .LEN_W(LW)) uut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .auto_len(auto_len),
    .dev_full(dev_full), .fifo_data(fifo_data), .fifo_wr(fifo_wr),
    .fifo_pktend(fifo_pktend)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (fifo_wr && lg < 64) begin
      log_d[lg]  <= fifo_data;
      log_pe[lg] <= fifo_pktend;
      log_c[lg]  <= cyc;
      lg <= lg + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_beat(input logic [DW-1:0] d, input logic last);
    bit r;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = last;
    forever begin
      #1 r = in_ready;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic start(input int len);
    @(negedge clk);
    auto_len = LW'(len);
    #1 lg = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 wr after reset", int'(fifo_wr), 0);
    chk("R1 pktend after reset", int'(fifo_pktend), 0);
    chk("R1 ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_auto_stream();
    start(4);
    for (int i = 0; i < 8; i++) send_beat(DW'(16'h100 + i), 1'b0);
    settle();
    chk("R2 write count", lg, 8);
    for (int i = 0; i < 8; i++) begin
      chk("R2 data order", int'(log_d[i]), 16'h100 + i);
      chk("R3 no pktend on auto", int'(log_pe[i]), 0);
    end
    chk("R2 back-to-back", log_c[7] - log_c[0], 7);
  endtask

  task automatic t_short();
    start(8);
    send_beat(16'h201, 1'b0);
    send_beat(16'h202, 1'b0);
    send_beat(16'h203, 1'b1);
    settle();
    chk("R4 write count", lg, 3);
    chk("R4 no early pktend", int'(log_pe[0]) + int'(log_pe[1]), 0);
    chk("R4 pktend with last", int'(log_pe[2]), 1);
    chk("R4 last data", int'(log_d[2]), 16'h203);
  endtask

  task automatic t_exact();
    start(4);
    for (int i = 0; i < 4; i++) send_beat(DW'(16'h300 + i), i == 3);
    send_beat(16'h310, 1'b0);
    send_beat(16'h311, 1'b1);
    settle();
    chk("R8 write count", lg, 6);
    for (int i = 0; i < 4; i++) chk("R8 no pktend on exact length", int'(log_pe[i]), 0);
    chk("R3 count restart short end", int'(log_pe[5]), 1);
    chk("R3 count restart no mid pktend", int'(log_pe[4]), 0);
  endtask

  task automatic t_one_after_auto();
    start(4);
    for (int i = 0; i < 4; i++) send_beat(DW'(16'h400 + i), 1'b0);
    send_beat(16'h4AA, 1'b1);
    settle();
    chk("R6 write count", lg, 5);
    chk("R6 one-beat pktend", int'(log_pe[4]), 1);
    chk("R6 one-beat data", int'(log_d[4]), 16'h4AA);
    chk("R6 idle cycle inserted", log_c[4] - log_c[3], 2);
  endtask

  task automatic t_two_after_auto();
    start(4);
    for (int i = 0; i < 4; i++) send_beat(DW'(16'h500 + i), 1'b0);
    send_beat(16'h5A0, 1'b0);
    send_beat(16'h5A1, 1'b1);
    settle();
    chk("R7 write count", lg, 6);
    chk("R7 no gap", log_c[5] - log_c[3], 2);
    chk("R7 pktend on second", int'(log_pe[5]), 1);
  endtask

  task automatic t_full();
    int seen;
    start(8);
    send_beat(16'h601, 1'b0);
    @(negedge clk);
    dev_full = 1'b1;
    in_valid = 1'b1; in_data = 16'h602; in_last = 1'b1;
    #1;
    chk("R5 ready low when full", int'(in_ready), 0);
    seen = lg;
    repeat (4) @(negedge clk);
    #1;
    chk("R5 no write while full", lg - seen, 0);
    dev_full = 1'b0;
    @(posedge clk);
    settle();
    chk("R5 write count", lg, 2);
    chk("R5 held data", int'(log_d[1]), 16'h602);
    chk("R5 held pktend", int'(log_pe[1]), 1);
  endtask

  task automatic t_len_one();
    start(1);
    for (int i = 0; i < 3; i++) send_beat(DW'(16'h700 + i), 1'b1);
    settle();
    chk("R9 write count", lg, 3);
    for (int i = 0; i < 3; i++) chk("R9 no pktend", int'(log_pe[i]), 0);
    chk("R9 no gap", log_c[2] - log_c[0], 2);
  endtask

  task automatic t_mid_reset();
    start(4);
    send_beat(16'h801, 1'b0);
    send_beat(16'h802, 1'b0);
    settle();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1 lg = 0;
    chk("R1 quiet after reset", int'(fifo_wr), 0);
    for (int i = 0; i < 3; i++) send_beat(DW'(16'h810 + i), i == 2);
    settle();
    chk("R1 write count", lg, 3);
    chk("R1 count cleared pktend", int'(log_pe[2]), 1);
  endtask

  initial begin
    t_reset();
    t_auto_stream();
    t_short();
    t_exact();
    t_one_after_auto();
    t_two_after_auto();
    t_full();
    t_len_one();
    t_mid_reset();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule